// File: doc/BRIEF.md
# Scatter-Gather Receive Descriptor Walker

This block places an incoming packet into a ring of buffer descriptors kept in system memory. Upstream logic announces a packet by its byte count together with five 32-bit sideband words. The walker then reads the descriptor that its current pointer selects. If the descriptor is free, the walker clips the transfer to that descriptor's buffer length and issues a length-only payload handshake for the buffer. It then writes the descriptor's status word back and follows the next pointer. Moving payload bytes is outside this block. The payload handshake carries only the buffer address and the byte count.

A packet may span several descriptors. The first descriptor of a packet is flagged as start of frame, and the one that finishes it is flagged as end of frame and also receives the sideband words. The walk stops for any of three reasons: the packet is fully placed, the descriptor just finished was the tail descriptor, or the fetched descriptor is already marked complete. The last two mark the channel idle. If the chain runs out while bytes remain, the rest of the packet is dropped and a sticky overflow flag is raised.

Descriptors are 64 bytes and little-endian. The 64-bit next pointer is at offset 0x00, the 64-bit buffer address at 0x08, the control word at 0x18, the status word at 0x1C, and the application words from 0x20 onward. Only the low 32-bit halves of the pointers are used. Memory traffic goes through a single valid/ready word port.

Top module: `s2m_walker`

## Requirements
- R1: A packet accepted while `run_i` is low, while `idle_o` is high, or with a length of zero makes no memory request and no payload handshake, and leaves the pointer, idle and overflow unchanged.
- R2: Each descriptor is fetched with four reads in ascending order, at the current pointer plus 0x00 (next pointer), 0x08 (buffer address), 0x18 (control) and 0x1C (status).
- R3: If the fetched status has bit 31 set, the walker writes nothing and sets `idle_o`, and the current pointer keeps its value.
- R4: The byte count placed in a descriptor is the smaller of control bits 22:0 and the bytes still left in the packet. It is offered on `xfer_len_o` with the buffer address, and no handshake is made when the count is zero.
- R5: The status written back is the fetched status OR'ed with bit 31 (complete), plus bit 27 (start of frame) only on the first descriptor of a packet.
- R6: On the descriptor that finishes the packet, the status also carries bit 26 (end of frame), and the five sideband words are written to offsets 0x20 to 0x30 before the status. `done_evt_o` pulses for one cycle right after that status write is accepted.
- R7: After the writeback the current pointer takes the fetched next pointer. If the finished descriptor was the tail descriptor, `idle_o` is set and the walk stops.
- R8: While bytes remain and the finished descriptor was not the tail, the walk continues with the next descriptor. When the packet ends before the tail, the walk stops and `idle_o` stays low.
- R9: `overflow_o` is set when the walk stops with bytes still unplaced, and it stays set until reset.
- R10: `cur_ld_i` loads the current pointer. `tail_ld_i` loads the tail pointer and clears `idle_o`.
- R11: A memory request holds its address, direction and data until it is accepted. After a read is accepted, no new request is raised until its response has arrived.
- R12: After reset, `pkt_ready_o` is high, no request is pending, `idle_o` and `overflow_o` are low, and the current pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Channel enabled |
| cur_ld_i | input | 1 | Load current descriptor pointer |
| cur_val_i | input | AW | Value for the current pointer |
| tail_ld_i | input | 1 | Load tail pointer, clears idle |
| tail_val_i | input | AW | Value for the tail pointer |
| pkt_valid_i | input | 1 | Packet announced |
| pkt_ready_o | output | 1 | Walker free to take a packet |
| pkt_len_i | input | PKT_W | Packet byte count |
| pkt_app_i | input | APP_N*32 | Sideband words, word 0 in the low bits |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | Request is a write |
| mem_req_addr_o | output | AW | Byte address of the word |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| xfer_valid_o | output | 1 | Payload placement request |
| xfer_ready_i | input | 1 | Payload placement done |
| xfer_addr_o | output | AW | Buffer address for the payload |
| xfer_len_o | output | 23 | Bytes placed in this buffer |
| cur_ptr_o | output | AW | Current descriptor pointer |
| idle_o | output | 1 | Channel idle (tail reached or busy descriptor met) |
| overflow_o | output | 1 | Sticky: packet bytes dropped |
| done_evt_o | output | 1 | One-cycle packet completion pulse |

## Verification
The bound checker watches the memory and payload handshakes on every cycle. It checks that requests stay stable while stalled and that only one read is in flight. It also checks that skipped packets make no traffic, that every status write carries the complete bit, that the completion pulse follows an end-of-frame status write, and that overflow stays set. Other behaviour only shows up in memory after a whole walk, so the bench scenarios cover it: how a packet is split over descriptors, which flags land in which descriptor, where the pointer ends up, and when idle and overflow are raised. The bench sweeps packet lengths against every tail position over a chain that includes a zero-length buffer.

// File: rtl/s2m_walk_pkg.sv
// Package: shared constants, descriptor offsets and walker state type.
// Assumes 64-byte little-endian descriptors; only low pointer words are used.
package s2m_walk_pkg;

    localparam int WORD_W  = 32;
    localparam int LEN_W   = 23;
    localparam int FETCH_N = 4;

    localparam logic [5:0] OFS_NEXT = 6'h00;
    localparam logic [5:0] OFS_BUF  = 6'h08;
    localparam logic [5:0] OFS_CTRL = 6'h18;
    localparam logic [5:0] OFS_STAT = 6'h1C;
    localparam logic [5:0] OFS_APP0 = 6'h20;

    localparam int BIT_DONE  = 31;
    localparam int BIT_FIRST = 27;
    localparam int BIT_LAST  = 26;

    typedef enum logic [2:0] {
        W_WAIT,
        W_RD_REQ,
        W_RD_RSP,
        W_EVAL,
        W_XFER,
        W_WB_REQ,
        W_ADV
    } walk_state_t;

    // Byte offset of the n-th fetched word, ascending.
    function automatic logic [5:0] fetch_ofs(input logic [1:0] idx);
        case (idx)
            2'd0:    return OFS_NEXT;
            2'd1:    return OFS_BUF;
            2'd2:    return OFS_CTRL;
            default: return OFS_STAT;
        endcase
    endfunction

endpackage

// File: rtl/s2m_len_clip.sv
// Module: computes the bytes placed in one descriptor and the bytes left.
// Assumes PKT_W <= LEN_W so the remaining count fits in the length width.
module s2m_len_clip #(
    parameter int PKT_W = 16,
    parameter int LEN_W = 23
) (
    input  logic [LEN_W-1:0] buf_len_i,
    input  logic [PKT_W-1:0] remain_i,
    output logic [LEN_W-1:0] place_o,
    output logic [PKT_W-1:0] remain_next_o,
    output logic             last_o
);

    logic [LEN_W-1:0] rem_ext;

    // Smaller of buffer length and remaining bytes.
    always_comb begin
        rem_ext       = LEN_W'(remain_i);
        place_o       = (rem_ext < buf_len_i) ? rem_ext : buf_len_i;
        remain_next_o = remain_i - PKT_W'(place_o);
        last_o        = (remain_next_o == '0);
    end

endmodule

// File: rtl/s2m_wb_word.sv
// Module: address and data of each writeback word (sideband words, then status).
// Assumes idx values 0..APP_N-1 select sideband words and APP_N selects status.
module s2m_wb_word
    import s2m_walk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int APP_N = 5,
    parameter int WB_W  = 3
) (
    input  logic [AW-1:0]         desc_i,
    input  logic [WB_W-1:0]       idx_i,
    input  logic [APP_N*32-1:0]   app_i,
    input  logic [31:0]           stat_i,
    input  logic                  first_i,
    input  logic                  last_i,
    output logic [AW-1:0]         addr_o,
    output logic [31:0]           data_o
);

    logic [31:0] app_w [APP_N];
    logic [31:0] stat_wb;

    // Split the sideband vector into words.
    for (genvar g = 0; g < APP_N; g++) begin : g_app
        assign app_w[g] = app_i[g*32 +: 32];
    end

    // Status value with the flags OR'ed in.
    always_comb begin
        stat_wb = stat_i | (32'd1 << BIT_DONE)
                | (32'(first_i) << BIT_FIRST)
                | (32'(last_i) << BIT_LAST);
    end

    // Select address and data for the current writeback index.
    always_comb begin
        addr_o = desc_i + AW'(OFS_STAT);
        data_o = stat_wb;
        for (int j = 0; j < APP_N; j++) begin
            if (idx_i == WB_W'(j)) begin
                addr_o = desc_i + AW'(OFS_APP0) + AW'(4 * j);
                data_o = app_w[j];
            end
        end
    end

endmodule

// File: rtl/s2m_chain_regs.sv
// Module: current and tail pointers, idle and sticky overflow flags.
// Assumes software loads do not collide with a walker advance.
module s2m_chain_regs #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cur_ld_i,
    input  logic [AW-1:0] cur_val_i,
    input  logic          tail_ld_i,
    input  logic [AW-1:0] tail_val_i,
    input  logic          adv_i,
    input  logic [AW-1:0] next_i,
    input  logic          set_idle_i,
    input  logic          set_ovf_i,
    output logic [AW-1:0] cur_o,
    output logic          at_tail_o,
    output logic          idle_o,
    output logic          ovf_o
);

    logic [AW-1:0] tail_q;

    // Current pointer: walker advance or software load.
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_o <= '0;
        else if (adv_i)    cur_o <= next_i;
        else if (cur_ld_i) cur_o <= cur_val_i;
    end

    // Tail pointer: software load only.
    always_ff @(posedge clk) begin
        if (!rst_n)         tail_q <= '0;
        else if (tail_ld_i) tail_q <= tail_val_i;
    end

    // Idle flag: set by the walker, cleared by a tail load.
    always_ff @(posedge clk) begin
        if (!rst_n)          idle_o <= 1'b0;
        else if (tail_ld_i)  idle_o <= 1'b0;
        else if (set_idle_i) idle_o <= 1'b1;
    end

    // Overflow flag: sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovf_o <= 1'b0;
        else if (set_ovf_i) ovf_o <= 1'b1;
    end

    assign at_tail_o = (cur_o == tail_q);

endmodule

// File: rtl/s2m_walker.sv
// Module: walks a descriptor chain for one received packet at a time.
// Assumes one outstanding read, a response arriving some cycles after accept,
// and writes that complete on accept.
module s2m_walker
    import s2m_walk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PKT_W = 16,
    parameter int APP_N = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                cur_ld_i,
    input  logic [AW-1:0]       cur_val_i,
    input  logic                tail_ld_i,
    input  logic [AW-1:0]       tail_val_i,
    input  logic                pkt_valid_i,
    output logic                pkt_ready_o,
    input  logic [PKT_W-1:0]    pkt_len_i,
    input  logic [APP_N*32-1:0] pkt_app_i,
    output logic                mem_req_valid_o,
    input  logic                mem_req_ready_i,
    output logic                mem_req_we_o,
    output logic [AW-1:0]       mem_req_addr_o,
    output logic [31:0]         mem_req_wdata_o,
    input  logic                mem_rsp_valid_i,
    input  logic [31:0]         mem_rsp_data_i,
    output logic                xfer_valid_o,
    input  logic                xfer_ready_i,
    output logic [AW-1:0]       xfer_addr_o,
    output logic [LEN_W-1:0]    xfer_len_o,
    output logic [AW-1:0]       cur_ptr_o,
    output logic                idle_o,
    output logic                overflow_o,
    output logic                done_evt_o
);

    localparam int WB_W = $clog2(APP_N + 1);
    localparam logic [WB_W-1:0] WB_STATUS = WB_W'(APP_N);
    localparam logic [1:0] RD_LAST = 2'(FETCH_N - 1);

    walk_state_t          state_q;
    logic [1:0]           rd_idx_q;
    logic [AW-1:0]        nxt_q;
    logic [AW-1:0]        buf_q;
    logic [LEN_W-1:0]     ctrl_q;
    logic [31:0]          stat_q;
    logic [PKT_W-1:0]     rem_q;
    logic                 first_q;
    logic [WB_W-1:0]      wb_idx_q;
    logic [APP_N*32-1:0]  app_q;
    logic                 done_q;

    logic                 pkt_fire;
    logic                 start_walk;
    logic [LEN_W-1:0]     place;
    logic [PKT_W-1:0]     rem_next;
    logic                 last;
    logic [WB_W-1:0]      wb_start;
    logic [AW-1:0]        wb_addr;
    logic [31:0]          wb_data;
    logic                 at_tail;
    logic                 adv;
    logic                 busy_hit;
    logic                 set_idle;
    logic                 set_ovf;

    // Packet acceptance and the decision to walk.
    always_comb begin
        pkt_ready_o = (state_q == W_WAIT);
        pkt_fire    = pkt_valid_i && pkt_ready_o;
        start_walk  = pkt_fire && run_i && !idle_o && (pkt_len_i != '0);
    end

    s2m_len_clip #(
        .PKT_W (PKT_W),
        .LEN_W (LEN_W)
    ) u_clip (
        .buf_len_i     (ctrl_q),
        .remain_i      (rem_q),
        .place_o       (place),
        .remain_next_o (rem_next),
        .last_o        (last)
    );

    s2m_wb_word #(
        .AW    (AW),
        .APP_N (APP_N),
        .WB_W  (WB_W)
    ) u_wb (
        .desc_i  (cur_ptr_o),
        .idx_i   (wb_idx_q),
        .app_i   (app_q),
        .stat_i  (stat_q),
        .first_i (first_q),
        .last_i  (last),
        .addr_o  (wb_addr),
        .data_o  (wb_data)
    );

    // Chain register updates requested by the walker.
    always_comb begin
        adv      = (state_q == W_ADV);
        busy_hit = (state_q == W_EVAL) && stat_q[BIT_DONE];
        set_idle = busy_hit || (adv && at_tail);
        set_ovf  = busy_hit || (adv && at_tail && (rem_next != '0));
        wb_start = last ? '0 : WB_STATUS;
    end

    s2m_chain_regs #(
        .AW (AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_ld_i   (cur_ld_i),
        .cur_val_i  (cur_val_i),
        .tail_ld_i  (tail_ld_i),
        .tail_val_i (tail_val_i),
        .adv_i      (adv),
        .next_i     (nxt_q),
        .set_idle_i (set_idle),
        .set_ovf_i  (set_ovf),
        .cur_o      (cur_ptr_o),
        .at_tail_o  (at_tail),
        .idle_o     (idle_o),
        .ovf_o      (overflow_o)
    );

    // Memory and payload request outputs.
    always_comb begin
        mem_req_valid_o = (state_q == W_RD_REQ) || (state_q == W_WB_REQ);
        mem_req_we_o    = (state_q == W_WB_REQ);
        mem_req_addr_o  = (state_q == W_WB_REQ) ? wb_addr
                                                : cur_ptr_o + AW'(fetch_ofs(rd_idx_q));
        mem_req_wdata_o = (state_q == W_WB_REQ) ? wb_data : '0;
        xfer_valid_o    = (state_q == W_XFER);
        xfer_addr_o     = buf_q;
        xfer_len_o      = place;
    end

    // Walker sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= W_WAIT;
            rd_idx_q <= '0;
            rem_q    <= '0;
            first_q  <= 1'b0;
            wb_idx_q <= '0;
            app_q    <= '0;
        end else begin
            case (state_q)
                W_WAIT: begin
                    if (start_walk) begin
                        rem_q    <= pkt_len_i;
                        app_q    <= pkt_app_i;
                        first_q  <= 1'b1;
                        rd_idx_q <= '0;
                        state_q  <= W_RD_REQ;
                    end
                end
                W_RD_REQ: begin
                    if (mem_req_ready_i) state_q <= W_RD_RSP;
                end
                W_RD_RSP: begin
                    if (mem_rsp_valid_i) begin
                        if (rd_idx_q == RD_LAST) begin
                            state_q <= W_EVAL;
                        end else begin
                            rd_idx_q <= rd_idx_q + 2'd1;
                            state_q  <= W_RD_REQ;
                        end
                    end
                end
                W_EVAL: begin
                    if (stat_q[BIT_DONE]) begin
                        state_q <= W_WAIT;
                    end else if (place != '0) begin
                        state_q <= W_XFER;
                    end else begin
                        wb_idx_q <= wb_start;
                        state_q  <= W_WB_REQ;
                    end
                end
                W_XFER: begin
                    if (xfer_ready_i) begin
                        wb_idx_q <= wb_start;
                        state_q  <= W_WB_REQ;
                    end
                end
                W_WB_REQ: begin
                    if (mem_req_ready_i) begin
                        if (wb_idx_q == WB_STATUS) state_q <= W_ADV;
                        else                       wb_idx_q <= wb_idx_q + 1'b1;
                    end
                end
                W_ADV: begin
                    rem_q    <= rem_next;
                    first_q  <= 1'b0;
                    rd_idx_q <= '0;
                    if (at_tail || (rem_next == '0)) state_q <= W_WAIT;
                    else                             state_q <= W_RD_REQ;
                end
                default: state_q <= W_WAIT;
            endcase
        end
    end

    // Capture fetched descriptor words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q  <= '0;
            buf_q  <= '0;
            ctrl_q <= '0;
            stat_q <= '0;
        end else if (state_q == W_RD_RSP && mem_rsp_valid_i) begin
            case (rd_idx_q)
                2'd0:    nxt_q  <= mem_rsp_data_i[AW-1:0];
                2'd1:    buf_q  <= mem_rsp_data_i[AW-1:0];
                2'd2:    ctrl_q <= mem_rsp_data_i[LEN_W-1:0];
                default: stat_q <= mem_rsp_data_i;
            endcase
        end
    end

    // Completion pulse one cycle after the final status write.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == W_WB_REQ) && mem_req_ready_i
                              && (wb_idx_q == WB_STATUS) && last;
    end

    assign done_evt_o = done_q;

endmodule

// File: rtl/s2m_walker_chk.sv
// Checker: handshake and flag properties of the descriptor walker.
// Assumes it is bound to s2m_walker; uses only its ports.
module s2m_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_i,
    input logic          pkt_valid_i,
    input logic          pkt_ready_o,
    input logic          mem_req_valid_o,
    input logic          mem_req_ready_i,
    input logic          mem_req_we_o,
    input logic [AW-1:0] mem_req_addr_o,
    input logic [31:0]   mem_req_wdata_o,
    input logic          xfer_valid_o,
    input logic          xfer_ready_i,
    input logic [AW-1:0] xfer_addr_o,
    input logic [22:0]   xfer_len_o,
    input logic [AW-1:0] cur_ptr_o,
    input logic          idle_o,
    input logic          overflow_o,
    input logic          done_evt_o
);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o
            && $stable(mem_req_addr_o) && $stable(mem_req_we_o) && $stable(mem_req_wdata_o));

    p_one_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && mem_req_ready_i && !mem_req_we_o |=> !mem_req_valid_o);

    p_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_i && pkt_ready_o && (!run_i || idle_o) |=> !mem_req_valid_o && pkt_ready_o);

    p_xfer_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o |-> xfer_len_o != '0);

    p_xfer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o && !xfer_ready_i |=> xfer_valid_o
            && $stable(xfer_len_o) && $stable(xfer_addr_o));

    p_status_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && mem_req_we_o && (mem_req_addr_o - cur_ptr_o == AW'(32'h1C))
            |-> mem_req_wdata_o[31]);

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt_o |-> $past(mem_req_valid_o && mem_req_ready_i && mem_req_we_o
            && mem_req_wdata_o[26]));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    p_idle_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> pkt_ready_o);

    p_quiet_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready_o |-> !mem_req_valid_o && !xfer_valid_o);

endmodule

bind s2m_walker s2m_walker_chk #(.AW(AW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .run_i           (run_i),
    .pkt_valid_i     (pkt_valid_i),
    .pkt_ready_o     (pkt_ready_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_we_o    (mem_req_we_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_wdata_o (mem_req_wdata_o),
    .xfer_valid_o    (xfer_valid_o),
    .xfer_ready_i    (xfer_ready_i),
    .xfer_addr_o     (xfer_addr_o),
    .xfer_len_o      (xfer_len_o),
    .cur_ptr_o       (cur_ptr_o),
    .idle_o          (idle_o),
    .overflow_o      (overflow_o),
    .done_evt_o      (done_evt_o)
);

// File: tb/s2m_walker_tb.sv
// Bench: four-descriptor ring in a word memory model, sweep of packet length
// against tail position, plus directed cases for skip, busy descriptor and reload.
module s2m_walker_tb;

    localparam int AW = 32;
    localparam int PKT_W = 16;
    localparam int APP_N = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                rst_n = 1'b0;
    logic                run = 1'b0;
    logic                cur_ld = 1'b0, tail_ld = 1'b0;
    logic [AW-1:0]       cur_val = '0, tail_val = '0;
    logic                pkt_valid = 1'b0;
    logic [PKT_W-1:0]    pkt_len = '0;
    logic [APP_N*32-1:0] pkt_app = '0;
    logic                pkt_ready;
    logic                mreq_v, mreq_we, mreq_rdy = 1'b0;
    logic [AW-1:0]       mreq_a;
    logic [31:0]         mreq_d;
    logic                mrsp_v = 1'b0;
    logic [31:0]         mrsp_d = '0;
    logic                xv, xr = 1'b0;
    logic [AW-1:0]       xa;
    logic [22:0]         xl;
    logic [AW-1:0]       cur;
    logic                idle, ovf, done;

    s2m_walker #(.AW(AW), .PKT_W(PKT_W), .APP_N(APP_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .cur_ld_i(cur_ld), .cur_val_i(cur_val), .tail_ld_i(tail_ld), .tail_val_i(tail_val),
        .pkt_valid_i(pkt_valid), .pkt_ready_o(pkt_ready), .pkt_len_i(pkt_len), .pkt_app_i(pkt_app),
        .mem_req_valid_o(mreq_v), .mem_req_ready_i(mreq_rdy), .mem_req_we_o(mreq_we),
        .mem_req_addr_o(mreq_a), .mem_req_wdata_o(mreq_d),
        .mem_rsp_valid_i(mrsp_v), .mem_rsp_data_i(mrsp_d),
        .xfer_valid_o(xv), .xfer_ready_i(xr), .xfer_addr_o(xa), .xfer_len_o(xl),
        .cur_ptr_o(cur), .idle_o(idle), .overflow_o(ovf), .done_evt_o(done)
    );

    logic [31:0] mem [0:127];
    logic [22:0] xlog [0:15];
    logic [31:0] rd_log [0:7];
    int cyc = 0, req_cnt = 0, done_cnt = 0, rd_n = 0;
    logic clr = 1'b0;
    int n_chk = 0, n_fail = 0;
    int dl [1:4];

    // Memory, payload and event model.
    always @(posedge clk) begin
        cyc    <= cyc + 1;
        mreq_rdy <= ((cyc % 3) != 1);
        mrsp_v <= 1'b0;
        xr     <= xv & ~xr;
        if (clr) begin
            req_cnt <= 0; done_cnt <= 0; rd_n <= 0;
            for (int i = 0; i < 16; i++) xlog[i] <= '0;
        end else begin
            if (mreq_v && mreq_rdy) begin
                req_cnt <= req_cnt + 1;
                if (mreq_we) mem[mreq_a[8:2]] <= mreq_d;
                else begin
                    mrsp_v <= 1'b1;
                    mrsp_d <= mem[mreq_a[8:2]];
                    if (rd_n < 8) rd_log[rd_n] <= mreq_a;
                    rd_n <= rd_n + 1;
                end
            end
            if (xv && xr) xlog[xa[15:12]] <= xl;
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; clr = 1'b0;
    endtask

    // Ring of four descriptors at 0x40*k, buffer at 0x1000*k.
    task automatic setup_chain();
        for (int k = 1; k <= 4; k++) begin
            for (int w = 0; w < 16; w++) mem[16*k + w] = 32'h0;
            mem[16*k + 0] = 32'(64 * ((k % 4) + 1));
            mem[16*k + 2] = 32'(32'h1000 * k);
            mem[16*k + 6] = 32'hFF80_0000 | 32'(dl[k]);
            for (int j = 0; j < 6; j++) mem[16*k + 8 + j] = 32'hA000_0000 | 32'(k << 8) | 32'(j);
        end
    endtask

    task automatic load_ptrs(input int ck, input int tk);
        @(negedge clk);
        cur_ld = 1'b1; cur_val = 32'(64 * ck);
        tail_ld = 1'b1; tail_val = 32'(64 * tk);
        @(negedge clk);
        cur_ld = 1'b0; tail_ld = 1'b0;
    endtask

    task automatic send(input int len);
        int guard;
        for (int j = 0; j < APP_N; j++) pkt_app[j*32 +: 32] = 32'hC0DE_0000 + 32'(len * 16 + j);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_len = PKT_W'(len);
        @(negedge clk);
        pkt_valid = 1'b0;
        guard = 0;
        while (!pkt_ready && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    // Expected outcome of one walk from descriptor 1 computed from the rules.
    task automatic expect_walk(input int plen, input int tk);
        int rem, k, idx, plc;
        bit lst, stop;
        logic [31:0] e;
        rem = plen; k = 1; idx = 0; stop = 0;
        while (!stop) begin
            plc = (dl[k] < rem) ? dl[k] : rem;
            rem -= plc;
            lst = (rem == 0);
            e = 32'h8000_0000 | (idx == 0 ? 32'h0800_0000 : 0) | (lst ? 32'h0400_0000 : 0);
            chk(mem[16*k + 7] == e, "R5 status", mem[16*k + 7], e);
            chk(xlog[k] == 23'(plc), "R4 placed", 32'(xlog[k]), 32'(plc));
            if (lst) begin
                for (int j = 0; j < APP_N; j++)
                    chk(mem[16*k + 8 + j] == pkt_app[j*32 +: 32], "R6 sideband",
                        mem[16*k + 8 + j], pkt_app[j*32 +: 32]);
                chk(mem[16*k + 13] == (32'hA000_0005 | 32'(k << 8)), "R6 sixth word",
                    mem[16*k + 13], 32'hA000_0005 | 32'(k << 8));
            end else begin
                chk(mem[16*k + 8] == (32'hA000_0000 | 32'(k << 8)), "R6 no sideband",
                    mem[16*k + 8], 32'hA000_0000 | 32'(k << 8));
            end
            if (lst || k == tk) begin
                stop = 1;
                chk(cur == 32'(64 * ((k % 4) + 1)), "R7 pointer", cur, 32'(64 * ((k % 4) + 1)));
                chk(idle == (k == tk), "R7 R8 idle", 32'(idle), 32'(k == tk));
                chk(ovf == (k == tk && rem > 0), "R9 overflow", 32'(ovf), 32'(k == tk && rem > 0));
                chk(done_cnt == (lst ? 1 : 0), "R6 done", 32'(done_cnt), 32'(lst));
                if (k < 4) chk(mem[16*(k+1) + 7] == 32'h0, "R8 untouched", mem[16*(k+1) + 7], 0);
            end
            k++; idx++;
        end
    endtask

    initial begin
        #(10 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        dl[1] = 4; dl[2] = 0; dl[3] = 5; dl[4] = 3;
        do_reset();
        @(negedge clk);
        // R12 reset state
        chk(pkt_ready && !mreq_v && !xv, "R12 quiet", {29'b0, pkt_ready, mreq_v, xv}, 32'h4);
        chk(!idle && !ovf && cur == 0, "R12 flags", {30'b0, idle, ovf} | cur, 0);

        // Sweep: packet length against tail position
        for (int tk = 1; tk <= 4; tk++) begin
            for (int p = 1; p <= 14; p++) begin
                do_reset(); setup_chain(); load_ptrs(1, tk);
                run = 1'b1;
                send(p);
                expect_walk(p, tk);
            end
        end

        // R2 fetch order and R5 low status bits kept
        do_reset(); setup_chain(); mem[16 + 7] = 32'h0000_0055; load_ptrs(1, 4);
        send(2);
        chk(rd_log[0] == 32'h40 && rd_log[1] == 32'h48 && rd_log[2] == 32'h58 && rd_log[3] == 32'h5C,
            "R2 order", rd_log[3], 32'h5C);
        chk(rd_n == 4, "R2 reads", 32'(rd_n), 4);
        chk(mem[16 + 7] == 32'h8C00_0055, "R5 keep bits", mem[16 + 7], 32'h8C00_0055);

        // R8 second packet starts fresh at descriptor 2 (zero length) then 3
        send(3);
        chk(mem[32 + 7] == 32'h8800_0000, "R8 R5 first of second", mem[32 + 7], 32'h8800_0000);
        chk(mem[48 + 7] == 32'h8400_0000, "R6 last of second", mem[48 + 7], 32'h8400_0000);
        chk(cur == 32'h100 && done_cnt == 2, "R7 second pointer", cur, 32'h100);

        // R3 busy descriptor stops the walk without writing
        do_reset(); setup_chain(); mem[32 + 7] = 32'h8000_0000; load_ptrs(1, 4);
        send(10);
        chk(mem[32 + 7] == 32'h8000_0000, "R3 no write", mem[32 + 7], 32'h8000_0000);
        chk(cur == 32'h80 && idle, "R3 idle pointer", cur, 32'h80);
        chk(ovf && done_cnt == 0, "R9 busy overflow", {31'b0, ovf}, 1);

        // R1 idle channel skips a packet
        begin
            int rc;
            rc = req_cnt;
            send(5);
            chk(req_cnt == rc && cur == 32'h80, "R1 idle skip", 32'(req_cnt - rc), 0);
        end

        // R10 tail load clears idle; cur load moves pointer
        load_ptrs(3, 4);
        chk(!idle && cur == 32'hC0, "R10 reload", cur, 32'hC0);
        chk(ovf, "R9 sticky", {31'b0, ovf}, 1);

        // R1 not running and zero length skip
        do_reset(); setup_chain(); load_ptrs(1, 4);
        run = 1'b0;
        send(6);
        chk(req_cnt == 0 && cur == 32'h40 && !idle, "R1 stopped", 32'(req_cnt), 0);
        run = 1'b1;
        send(0);
        chk(req_cnt == 0 && !ovf && done_cnt == 0, "R1 zero length", 32'(req_cnt), 0);
        chk(mem[16 + 7] == 0, "R1 memory kept", mem[16 + 7], 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule